// File: doc/BRIEF.md
# DRAM Refresh and Low-Power Sequencer

This controller-side block keeps a DRAM array refreshed and drives its clock-enable pin through the power-down and self-refresh states. A free-running clock counter makes one auto-refresh owed every `REF_INTERVAL` clocks. The default of 3120 is 7.8 µs at 400 MHz, which gives 4096 refreshes in 32 ms. Owed refreshes pile up in a saturating backlog of up to `MAX_DEBT` entries. When the backlog is full, an urgency flag tells the command scheduler to yield.

The block shares the command bus through a request/grant handshake. It raises `busreq`, and the scheduler answers with `busgnt` once it has stopped issuing commands. From then on the bus belongs to this block until `busreq` falls. While it owns the bus the block does the following:
- It closes any open bank with a precharge-all and waits tRP.
- It issues the refresh and holds the bus for tRFC.
- It enters self-refresh: a refresh strobe with clock-enable low.
- On self-refresh exit it holds the bus for the long exit wait before any read.
- It enters power-down when no burst is in flight and leaves it after a three-clock wake-up.

The controller states are as follows:
- IDLE: owns nothing.
- ASK: requests the bus and chooses an action when the grant arrives.
- PRE, then TRP: precharge-all, then the tRP wait.
- REF, then TRFC: the refresh strobe, then the tRFC hold.
- SR_IN, SR, SR_OUT: self-refresh entry strobe, resident state, and exit wait.
- PD, PD_OUT: power-down resident state and its exit wait.

The transitions are as follows:
- IDLE→ASK: when anything is pending.
- ASK→IDLE: when the requests vanish before a grant.
- ASK→PRE: when granted with a bank open and a refresh or self-refresh pending.
- ASK→SR_IN: on a self-refresh request.
- ASK→REF: when a refresh is owed.
- ASK→PD: on a power-down request with no burst in flight.
- PRE→TRP→ASK: after the precharge.
- REF→TRFC→IDLE: after the refresh.
- SR_IN→SR→SR_OUT→IDLE: through self-refresh.
- PD→PD_OUT→IDLE: through power-down.

Top module: `dram_refresh_pm`

## Requirements
- R1: Out of reset `cke` is 1 and `busreq`, `pre_all`, `ref_cmd` and `ref_urgent` are 0.
- R2: One refresh becomes owed every `REF_INTERVAL` clocks. While a refresh is owed, `busreq` is raised. `pre_all` and `ref_cmd` pulse only while `busgnt` is 1.
- R3: `ref_urgent` is 1 exactly when the backlog equals `MAX_DEBT` (8 by default). With no grant for 7.5 intervals it is 0, and after 8.5 intervals it is 1.
- R4: The backlog saturates at `MAX_DEBT`. Each `ref_cmd` with `cke`=1 retires one owed refresh. After ten ungranted intervals, granting the bus yields exactly 8 refreshes.
- R5: After a `ref_cmd` with `cke`=1, `busreq` stays 1 for exactly `TRFC` more clocks. No `pre_all` or `ref_cmd` is issued in those clocks.
- R6: If `banks_open` is 1 when the grant arrives for a refresh, one `pre_all` pulse comes first. `ref_cmd` follows at least `TRP`+1 clocks later. `ref_cmd` never pulses while `banks_open` is 1.
- R7: A self-refresh request takes priority over owed refreshes. Entry is a `ref_cmd` pulse in the same clock that `cke` goes to 0, and `cke` stays 0 while `sr_req` is held.
- R8: When `sr_req` drops, `cke` returns to 1. `busreq` then stays 1 for exactly `TXSR` clocks, counting the clock in which `cke` rose.
- R9: During self-refresh the interval counter is held and the backlog is cleared. No refresh is requested until a full `REF_INTERVAL` after the block returns to IDLE.
- R10: Power-down entry (`cke` falling without `ref_cmd`) happens only after a grant and only while `burst_busy` is 0.
- R11: When `pd_req` drops in power-down, `cke` returns to 1. `busreq` then stays 1 for exactly `TXP` clocks, counting the rise clock.
- R12: In power-down with `pd_req` still held, a full backlog forces an exit. The owed refreshes then issue, and power-down is re-entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busgnt | input | 1 | Scheduler grants the command bus to this block |
| banks_open | input | 1 | At least one bank has an open row |
| burst_busy | input | 1 | A read or write burst is in flight |
| sr_req | input | 1 | Hold high to stay in self-refresh |
| pd_req | input | 1 | Hold high to stay in power-down |
| busreq | output | 1 | Request for, and ownership of, the command bus |
| pre_all | output | 1 | One-clock precharge-all strobe |
| ref_cmd | output | 1 | One-clock refresh strobe (self-refresh entry when cke is 0) |
| cke | output | 1 | DRAM clock-enable |
| ref_urgent | output | 1 | Refresh backlog is full |

## Verification
The properties assume the scheduler plays the handshake fairly. It raises `busgnt` only while `busreq` is high, and once it grants it keeps the grant until `busreq` falls. They also assume that `banks_open` drops after a `pre_all` and that `burst_busy` is low whenever the block is granted for a self-refresh entry. The bench drives `busgnt` as a half-clock-delayed copy of `busreq`, gated by a phase enable, and clears its bank model on the `pre_all` strobe. It raises `burst_busy` only during the power-down phase, and only before the block enters power-down.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ASK,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_TRFC,
        ST_SR_IN,
        ST_SR,
        ST_SR_OUT,
        ST_PD,
        ST_PD_OUT
    } rpm_state_e;
endpackage

// File: rtl/rpm_interval_tick.sv
module rpm_interval_tick #(
    parameter int INTERVAL = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !hold && (cnt == LAST);
endmodule

// File: rtl/rpm_debt_counter.sv
module rpm_debt_counter #(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic pending,
    output logic urgent
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

    logic [DW-1:0] debt;
    logic          inc_eff;
    logic          dec_eff;

    assign inc_eff = inc && ((debt != FULL) || dec);
    assign dec_eff = dec && (debt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            debt <= '0;
        end else begin
            unique case ({inc_eff, dec_eff})
                2'b10:   debt <= debt + 1'b1;
                2'b01:   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign pending = (debt != '0);
    assign urgent  = (debt == FULL);
endmodule

// File: rtl/rpm_wait_timer.sv
module rpm_wait_timer #(
    parameter int MAXW = 200,
    parameter int CW   = $clog2(MAXW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dram_refresh_pm.sv
module dram_refresh_pm
    import rpm_pkg::*;
#(
    parameter int REF_INTERVAL = 3120,
    parameter int MAX_DEBT     = 8,
    parameter int TRFC         = 20,
    parameter int TRP          = 6,
    parameter int TXSR         = 200,
    parameter int TXP          = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busgnt,
    input  logic banks_open,
    input  logic burst_busy,
    input  logic sr_req,
    input  logic pd_req,
    output logic busreq,
    output logic pre_all,
    output logic ref_cmd,
    output logic cke,
    output logic ref_urgent
);
    localparam int TMAX_A = (TRFC > TRP) ? TRFC : TRP;
    localparam int TMAX_B = (TXSR > TXP) ? TXSR : TXP;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW     = $clog2(TMAX + 1);

    localparam logic [TW-1:0] LD_TRP  = TW'(TRP - 1);
    localparam logic [TW-1:0] LD_TRFC = TW'(TRFC - 1);
    localparam logic [TW-1:0] LD_TXSR = TW'(TXSR - 1);
    localparam logic [TW-1:0] LD_TXP  = TW'(TXP - 1);

    rpm_state_e state, nxt;

    logic          tick;
    logic          pending;
    logic          urgent;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_done;
    logic          in_sr;
    logic          debt_dec;
    logic          debt_clr;

    assign in_sr    = (state == ST_SR_IN) || (state == ST_SR) || (state == ST_SR_OUT);
    assign debt_dec = (state == ST_REF);
    assign debt_clr = (state == ST_SR_IN);

    rpm_interval_tick #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (in_sr),
        .tick  (tick)
    );

    rpm_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (debt_dec),
        .clr     (debt_clr),
        .pending (pending),
        .urgent  (urgent)
    );

    rpm_wait_timer #(.MAXW(TMAX), .CW(TW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and timer loads
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (sr_req || pending || pd_req) begin
                    nxt = ST_ASK;
                end
            end
            ST_ASK: begin
                if (busgnt) begin
                    if (sr_req || pending) begin
                        if (banks_open) begin
                            nxt = ST_PRE;
                        end else if (sr_req) begin
                            nxt = ST_SR_IN;
                        end else begin
                            nxt = ST_REF;
                        end
                    end else if (pd_req) begin
                        if (!burst_busy) begin
                            nxt = ST_PD;
                        end
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else if (!(sr_req || pending || pd_req)) begin
                    nxt = ST_IDLE;
                end
            end
            ST_PRE: begin
                t_load = 1'b1;
                t_val  = LD_TRP;
                nxt    = ST_TRP;
            end
            ST_TRP: begin
                if (t_done) begin
                    nxt = ST_ASK;
                end
            end
            ST_REF: begin
                t_load = 1'b1;
                t_val  = LD_TRFC;
                nxt    = ST_TRFC;
            end
            ST_TRFC: begin
                if (t_done) begin
                    nxt = ST_IDLE;
                end
            end
            ST_SR_IN: begin
                nxt = ST_SR;
            end
            ST_SR: begin
                if (!sr_req) begin
                    t_load = 1'b1;
                    t_val  = LD_TXSR;
                    nxt    = ST_SR_OUT;
                end
            end
            ST_SR_OUT: begin
                if (t_done) begin
                    nxt = ST_IDLE;
                end
            end
            ST_PD: begin
                if (!pd_req || urgent) begin
                    t_load = 1'b1;
                    t_val  = LD_TXP;
                    nxt    = ST_PD_OUT;
                end
            end
            ST_PD_OUT: begin
                if (t_done) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        busreq  = (state != ST_IDLE);
        pre_all = (state == ST_PRE);
        ref_cmd = (state == ST_REF) || (state == ST_SR_IN);
        cke     = !((state == ST_SR_IN) || (state == ST_SR) || (state == ST_PD));
    end

    assign ref_urgent = urgent;
endmodule

// File: rtl/dram_refresh_pm_chk.sv
module dram_refresh_pm_chk #(
    parameter int TRFC = 20,
    parameter int TXSR = 200
) (
    input logic clk,
    input logic rst_n,
    input logic busgnt,
    input logic banks_open,
    input logic burst_busy,
    input logic busreq,
    input logic pre_all,
    input logic ref_cmd,
    input logic cke
);
    localparam int RW = $clog2(TRFC + 1);
    localparam int XW = $clog2(TXSR + 1);

    logic [RW-1:0] rfc_left;
    logic [XW-1:0] xs_left;
    logic          sr_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfc_left <= '0;
            xs_left  <= '0;
            sr_flag  <= 1'b0;
        end else begin
            if (ref_cmd && cke) begin
                rfc_left <= RW'(TRFC);
            end else if (rfc_left != '0) begin
                rfc_left <= rfc_left - 1'b1;
            end
            if (ref_cmd && !cke) begin
                sr_flag <= 1'b1;
            end else if (cke) begin
                sr_flag <= 1'b0;
            end
            if (sr_flag && cke) begin
                xs_left <= XW'(TXSR - 1);
            end else if (xs_left != '0) begin
                xs_left <= xs_left - 1'b1;
            end
        end
    end

    AST_CMD_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all || ref_cmd) |-> busgnt); // R2
    AST_TRFC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rfc_left != '0) |-> (busreq && !ref_cmd && !pre_all)); // R5
    AST_REF_BANKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> !banks_open); // R6
    AST_CKE_LOW_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> busreq); // R7
    AST_TXSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xs_left != '0) |-> (busreq && !ref_cmd)); // R8
    AST_CKE_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!burst_busy && busgnt)); // R10
endmodule

bind dram_refresh_pm dram_refresh_pm_chk #(.TRFC(TRFC), .TXSR(TXSR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busgnt     (busgnt),
    .banks_open (banks_open),
    .burst_busy (burst_busy),
    .busreq     (busreq),
    .pre_all    (pre_all),
    .ref_cmd    (ref_cmd),
    .cke        (cke)
);

// File: tb/dram_refresh_pm_test.sv
module dram_refresh_pm_test;
    localparam int INT  = 400;
    localparam int MAXD = 8;
    localparam int TRFC = 20;
    localparam int TRP  = 6;
    localparam int TXSR = 200;
    localparam int TXP  = 3;

    localparam int EV_PRE = 1;
    localparam int EV_REF = 2;
    localparam int EV_SRE = 3;
    localparam int EV_CKD = 4;
    localparam int EV_CKU = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busgnt = 1'b0;
    logic banks_open = 1'b0;
    logic burst_busy = 1'b0;
    logic sr_req = 1'b0;
    logic pd_req = 1'b0;
    logic busreq, pre_all, ref_cmd, cke, ref_urgent;

    logic gnt_en = 1'b0;
    logic open_req = 1'b0;

    int comp = 0;
    int miss = 0;
    int cyc = 0;
    int exp_q[$];
    string tag_q[$];
    int exp_wake = TXSR;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dram_refresh_pm #(
        .REF_INTERVAL(INT), .MAX_DEBT(MAXD), .TRFC(TRFC),
        .TRP(TRP), .TXSR(TXSR), .TXP(TXP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .busgnt(busgnt), .banks_open(banks_open),
        .burst_busy(burst_busy), .sr_req(sr_req), .pd_req(pd_req),
        .busreq(busreq), .pre_all(pre_all), .ref_cmd(ref_cmd), .cke(cke),
        .ref_urgent(ref_urgent)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        comp++;
        if (!ok) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int ev, input string tag);
        exp_q.push_back(ev);
        tag_q.push_back(tag);
    endtask

    task automatic got(input int ev);
        if (exp_q.size() == 0) begin
            check(1'b0, "unexpected event", ev, 0);
        end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(ev == e, t, ev, e);
        end
    endtask

    task automatic drain(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // scheduler model: grant follows request, bank tracker closes on precharge-all
    always @(negedge clk) begin
        busgnt <= gnt_en && busreq;
        if (pre_all) banks_open <= 1'b0;
        else if (open_req) banks_open <= 1'b1;
    end

    // monitor
    bit prev_cke = 1'b1;
    bit pre_seen = 1'b0;
    int pre_cyc = 0;
    bit rf_run = 1'b0;
    int rf_cnt = 0;
    bit wk_run = 1'b0;
    int wk_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pre_all) begin
                got(EV_PRE);
                pre_seen = 1'b1;
                pre_cyc = cyc;
            end
            if (ref_cmd && !cke) begin
                got(EV_SRE);
            end else if (ref_cmd) begin
                got(EV_REF);
                if (pre_seen) begin
                    check(cyc - pre_cyc >= TRP + 1, "R6 precharge gap", cyc - pre_cyc, TRP + 1);
                    pre_seen = 1'b0;
                end
            end
            if (!cke && prev_cke && !ref_cmd) got(EV_CKD);
            if (rf_run) begin
                if (busreq) rf_cnt++;
                else begin
                    check(rf_cnt == TRFC, "R5 tRFC hold", rf_cnt, TRFC);
                    rf_run = 1'b0;
                end
            end
            if (ref_cmd && cke) begin
                rf_run = 1'b1;
                rf_cnt = 0;
            end
            if (wk_run) begin
                if (busreq) wk_cnt++;
                else begin
                    check(wk_cnt == exp_wake, (exp_wake == TXSR) ? "R8 exit hold" : "R11 exit hold",
                          wk_cnt, exp_wake);
                    wk_run = 1'b0;
                end
            end
            if (cke && !prev_cke) begin
                got(EV_CKU);
                wk_run = 1'b1;
                wk_cnt = 1;
            end
            prev_cke = cke;
            cyc++;
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", comp, miss);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cke == 1'b1, "R1 cke", cke, 1);
        check(busreq == 1'b0, "R1 busreq", busreq, 0);
        check(ref_cmd == 1'b0 && pre_all == 1'b0, "R1 strobes", ref_cmd, 0);
        check(ref_urgent == 1'b0, "R1 urgent", ref_urgent, 0);
        rst_n = 1'b1;

        // R2 interval, R3 urgency, R4 saturation
        wait_until(INT - 10);
        check(busreq == 1'b0, "R2 before interval", busreq, 0);
        wait_until(INT + 10);
        check(busreq == 1'b1, "R2 after interval", busreq, 1);
        wait_until(7 * INT + INT / 2);
        check(ref_urgent == 1'b0, "R3 seven owed", ref_urgent, 0);
        wait_until(8 * INT + INT / 2);
        check(ref_urgent == 1'b1, "R3 eight owed", ref_urgent, 1);
        wait_until(10 * INT + 50);
        for (int i = 0; i < MAXD; i++) expect_ev(EV_REF, "R4 backlog");
        gnt_en = 1'b1;
        wait_until(10 * INT + 50 + MAXD * 22 + 40);
        check(busreq == 1'b0, "R4 backlog retired", busreq, 0);
        check(ref_urgent == 1'b0, "R4 urgent cleared", ref_urgent, 1'b0);
        drain("R4 exactly eight");

        // R6 precharge before refresh
        @(negedge clk); open_req = 1'b1;
        @(negedge clk); open_req = 1'b0;
        expect_ev(EV_PRE, "R6 precharge first");
        expect_ev(EV_REF, "R6 refresh after");
        wait_until(11 * INT + 60);
        drain("R6 sequence");

        // R7 self-refresh entry, R8 exit, R9 held interval
        expect_ev(EV_SRE, "R7 entry strobe");
        sr_req = 1'b1;
        wait_until(11 * INT + 80);
        check(cke == 1'b0, "R7 cke low", cke, 0);
        wait_until(11 * INT + 960);
        check(cke == 1'b0, "R7 cke held", cke, 0);
        exp_wake = TXSR;
        expect_ev(EV_CKU, "R8 cke rise");
        sr_req = 1'b0;
        wait_until(11 * INT + 960 + TXSR + 50);
        check(busreq == 1'b0, "R9 no request after exit", busreq, 0);
        wait_until(11 * INT + 960 + TXSR + INT - 20);
        check(busreq == 1'b0, "R9 interval restarted", busreq, 0);
        expect_ev(EV_REF, "R9 first refresh");
        wait_until(11 * INT + 960 + TXSR + INT + 40);
        drain("R9 sequence");

        // R10 power-down entry gated by burst, R11 exit
        wait_until(6010);
        burst_busy = 1'b1;
        pd_req = 1'b1;
        wait_until(6030);
        check(cke == 1'b1, "R10 blocked by burst", cke, 1);
        expect_ev(EV_CKD, "R10 entry");
        burst_busy = 1'b0;
        wait_until(6036);
        check(cke == 1'b0, "R10 cke low", cke, 0);
        wait_until(6076);
        exp_wake = TXP;
        expect_ev(EV_CKU, "R11 exit");
        pd_req = 1'b0;
        wait_until(6096);
        check(cke == 1'b1, "R11 cke high", cke, 1);
        drain("R11 sequence");

        // R12 urgent exit from power-down
        expect_ev(EV_CKD, "R12 entry");
        pd_req = 1'b1;
        wait_until(9100);
        check(cke == 1'b0, "R12 still down", cke, 0);
        expect_ev(EV_CKU, "R12 forced exit");
        for (int i = 0; i < MAXD; i++) expect_ev(EV_REF, "R12 owed refresh");
        expect_ev(EV_CKD, "R12 re-entry");
        wait_until(9400);
        check(cke == 1'b0, "R12 re-entered", cke, 0);
        expect_ev(EV_CKU, "R11 final exit");
        pd_req = 1'b0;
        wait_until(9430);
        drain("R12 sequence");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", comp, miss);
        $finish;
    end
endmodule